// File: doc/BRIEF.md
# Indirect Register Window Behind a Byte-Serial Slave

This block sits between a byte-oriented I2C slave engine and an internal 32-bit register bus. The engine hands it three kinds of byte event: load a new value into the 8-bit pointer, write one byte at the pointer, or request one byte from the pointer. The pointer spans 256 byte addresses. Four local 32-bit registers are mapped in that space: a target address for bus writes, the data for bus writes, a target address for bus reads, and the data returned by the last bus read. Every other byte address reads as zero.

A bus write starts when the most significant byte of the write-data word is written. A bus read starts when the least significant byte of the read-data word is requested. In both cases the pointer jumps back to the start of the data word. An external master can therefore stream any number of whole 32-bit words through one data register in a single transfer. While a bus access is in flight, `busy` tells the engine to stretch the serial clock. A byte request that needs a bus read is answered only after the bus acknowledge.

Top module: `ind_win_top`

## Requirements
- R1: After reset the pointer is 0x00, all four registers are zero, and `busy`, `bus_req` and `rd_vld` are low.
- R2: `ptr_load` copies `ptr_val` into the pointer. Any value 0x00 to 0xFF is accepted, and `ptr_out` shows it one cycle later.
- R3: Write-address bytes live at 0x00–0x03, write-data at 0x04–0x07, read-address at 0x10–0x13 and read-data at 0x14–0x17. In each word the lowest byte address holds bits 7:0 and the highest holds bits 31:24. The first three words read back what was written.
- R4: An unmapped byte address reads as 0x00, and a write to it changes no register. A write to any byte of the read-data word (0x14–0x17) also leaves every register unchanged.
- R5: After a byte access the pointer moves up by one, except at 0x07, 0x17 and 0xFF. At 0xFF it stays at 0xFF for both reads and writes.
- R6: A write at 0x07 stores bits 31:24 of write-data, then issues a bus write (`bus_we`=1) of the full write-data word to the write-address with bits 1:0 forced to zero. The pointer returns to 0x04. A read at 0x07 moves the pointer to 0x08.
- R7: A read request at 0x14 issues a bus read (`bus_we`=0) at the read-address with bits 1:0 forced to zero. `rd_vld` stays low until `bus_ack`. The acknowledged data is then stored in read-data, its bits 7:0 are returned, and the pointer becomes 0x15. Reads at 0x15–0x17 return bits 15:8, 23:16 and 31:24 of the stored word.
- R8: A read at 0x17 returns the pointer to 0x14. A write at 0x17 is discarded and moves the pointer to 0x18.
- R9: `busy` and `bus_req` rise in the cycle after the launching access and stay high until the cycle after `bus_ack`. While `busy` is high, all three strobes are ignored.
- R10: A byte request that needs no bus access gives a one-cycle `rd_vld` pulse in the cycle after the request.
- R11: When several strobes arrive in one idle cycle, `ptr_load` wins over `wr_stb`, which wins over `rd_req`. The losing strobes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_load | input | 1 | Load pointer strobe |
| ptr_val | input | 8 | New pointer value |
| wr_stb | input | 1 | Byte write strobe |
| wr_byte | input | 8 | Byte to write at the pointer |
| rd_req | input | 1 | Byte read request strobe |
| rd_vld | output | 1 | Read byte valid pulse |
| rd_byte | output | 8 | Returned byte |
| ptr_out | output | 8 | Current pointer value |
| busy | output | 1 | Bus access in flight; stretch the serial clock |
| bus_req | output | 1 | Internal bus request |
| bus_we | output | 1 | 1 for a bus write, 0 for a bus read |
| bus_addr | output | 32 | Word-aligned bus address |
| bus_wdata | output | 32 | Bus write data |
| bus_ack | input | 1 | Bus acknowledge, one cycle |
| bus_rdata | input | 32 | Bus read data, valid with `bus_ack` |

## Verification
The pointer, the register contents and a plain read's `rd_valid`/`rd_byte` all change one cycle after the strobe. The bench steps one clock past each strobe and samples there, away from the edge. `busy`, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` appear one cycle after the launching access. Their end time depends on the bus model's acknowledge latency, so the bench polls `busy` or `rd_vld` with a bounded loop. It checks the returned byte, the bus fields it logged and the pointer only after that loop ends. Before the acknowledge, the bench checks right after the launch cycle that `rd_vld` is still low.

// File: rtl/ind_win_pkg.sv
package ind_win_pkg;

    localparam int PTR_W  = 8;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int SLOT_W = PTR_W - LANE_W;

    localparam logic [PTR_W-1:0] A_WADDR     = 8'h00;
    localparam logic [PTR_W-1:0] A_WDATA     = 8'h04;
    localparam logic [PTR_W-1:0] A_RADDR     = 8'h10;
    localparam logic [PTR_W-1:0] A_RDATA     = 8'h14;
    localparam logic [PTR_W-1:0] A_WDATA_MSB = A_WDATA + PTR_W'(LANES - 1);
    localparam logic [PTR_W-1:0] A_RDATA_MSB = A_RDATA + PTR_W'(LANES - 1);
    localparam logic [PTR_W-1:0] A_TOP       = {PTR_W{1'b1}};

    localparam logic [WORD_W-1:0] ALIGN_MASK = {{(WORD_W-LANE_W){1'b1}}, {LANE_W{1'b0}}};

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_WRITE = 2'd1,
        SQ_READ  = 2'd2
    } sq_e;

    typedef enum logic [2:0] {
        REG_NONE  = 3'd0,
        REG_WADDR = 3'd1,
        REG_WDATA = 3'd2,
        REG_RADDR = 3'd3,
        REG_RDATA = 3'd4
    } reg_e;

    typedef struct packed {
        logic [WORD_W-1:0] waddr;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] raddr;
        logic [WORD_W-1:0] rdata;
    } win_regs_t;

    typedef struct packed {
        sq_e               st;
        logic              vld;
        logic [BYTE_W-1:0] rbyte;
    } seq_state_t;

    function automatic reg_e decode_slot(input logic [PTR_W-1:0] a);
        logic [SLOT_W-1:0] s;
        s = a[PTR_W-1:LANE_W];
        if (s == A_WADDR[PTR_W-1:LANE_W])      return REG_WADDR;
        else if (s == A_WDATA[PTR_W-1:LANE_W]) return REG_WDATA;
        else if (s == A_RADDR[PTR_W-1:LANE_W]) return REG_RADDR;
        else if (s == A_RDATA[PTR_W-1:LANE_W]) return REG_RDATA;
        else                                   return REG_NONE;
    endfunction

endpackage

// File: rtl/ind_win_ptr.sv
module ind_win_ptr
    import ind_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [PTR_W-1:0] load_val,
    input  logic             adv_wr,
    input  logic             adv_rd,
    input  logic             fetch_done,
    output logic [PTR_W-1:0] ptr_q
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } ptr_state_t;

    ptr_state_t d, q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        if (p == A_TOP) return p;
        else            return p + PTR_W'(1);
    endfunction

    always_comb begin
        d = q;
        if (load) begin
            d.ptr = load_val;
        end else if (adv_wr) begin
            if (q.ptr == A_WDATA_MSB) d.ptr = A_WDATA;
            else                      d.ptr = step(q.ptr);
        end else if (adv_rd) begin
            if (q.ptr == A_RDATA_MSB) d.ptr = A_RDATA;
            else                      d.ptr = step(q.ptr);
        end else if (fetch_done) begin
            d.ptr = A_RDATA + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ptr_q = q.ptr;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ptr_q == $past(load_val)); // R2
    AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_wr || adv_rd) && ptr_q == A_TOP |=> ptr_q == A_TOP); // R5
    AST_WDATA_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        adv_wr && ptr_q == A_WDATA_MSB |=> ptr_q == A_WDATA); // R6
    AST_RDATA_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        adv_rd && ptr_q == A_RDATA_MSB |=> ptr_q == A_RDATA); // R8
    AST_FETCH_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> ptr_q == A_RDATA + PTR_W'(1)); // R7

endmodule

// File: rtl/ind_win_regs.sv
module ind_win_regs
    import ind_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              ld_rdata,
    input  logic [WORD_W-1:0] bus_rdata,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [WORD_W-1:0] waddr,
    output logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] raddr
);

    win_regs_t d, q;

    logic [BYTE_W-1:0] waddr_l [LANES];
    logic [BYTE_W-1:0] wdata_l [LANES];
    logic [BYTE_W-1:0] raddr_l [LANES];
    logic [BYTE_W-1:0] rdata_l [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign waddr_l[g] = q.waddr[g*BYTE_W +: BYTE_W];
        assign wdata_l[g] = q.wdata[g*BYTE_W +: BYTE_W];
        assign raddr_l[g] = q.raddr[g*BYTE_W +: BYTE_W];
        assign rdata_l[g] = q.rdata[g*BYTE_W +: BYTE_W];
    end

    logic [LANE_W-1:0] wlane;
    logic [LANE_W-1:0] rlane;
    assign wlane = wr_addr[LANE_W-1:0];
    assign rlane = rd_addr[LANE_W-1:0];

    always_comb begin
        d = q;
        if (wr_en) begin
            unique case (decode_slot(wr_addr))
                REG_WADDR: d.waddr[int'(wlane)*BYTE_W +: BYTE_W] = wr_byte;
                REG_WDATA: d.wdata[int'(wlane)*BYTE_W +: BYTE_W] = wr_byte;
                REG_RADDR: d.raddr[int'(wlane)*BYTE_W +: BYTE_W] = wr_byte;
                default:   ;
            endcase
        end
        if (ld_rdata) d.rdata = bus_rdata;
    end

    always_comb begin
        unique case (decode_slot(rd_addr))
            REG_WADDR: rd_byte = waddr_l[rlane];
            REG_WDATA: rd_byte = wdata_l[rlane];
            REG_RADDR: rd_byte = raddr_l[rlane];
            REG_RDATA: rd_byte = rdata_l[rlane];
            default:   rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign waddr = q.waddr;
    assign wdata = q.wdata;
    assign raddr = q.raddr;

    AST_RDATA_ONLY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_rdata |=> $stable(q.rdata)); // R4
    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(q.waddr) && $stable(q.wdata) && $stable(q.raddr)); // R9

endmodule

// File: rtl/ind_win_seq.sv
module ind_win_seq
    import ind_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_load,
    input  logic              wr_stb,
    input  logic              rd_req,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [WORD_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] raddr,
    input  logic [BYTE_W-1:0] mux_byte,
    input  logic [BYTE_W-1:0] ack_byte,
    input  logic              bus_ack,
    output logic              acc_load,
    output logic              acc_wr,
    output logic              acc_rd_plain,
    output logic              fetch_done,
    output logic              busy,
    output logic              bus_req,
    output logic              bus_we,
    output logic [WORD_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    output logic              rd_vld,
    output logic [BYTE_W-1:0] rd_byte
);

    seq_state_t d, q;
    logic idle, acc_rd, fetch, launch;

    always_comb begin
        idle         = (q.st == SQ_IDLE);
        acc_load     = idle && ptr_load;
        acc_wr       = idle && !ptr_load && wr_stb;
        acc_rd       = idle && !ptr_load && !wr_stb && rd_req;
        fetch        = acc_rd && (ptr == A_RDATA);
        acc_rd_plain = acc_rd && !fetch;
        launch       = acc_wr && (ptr == A_WDATA_MSB);
        fetch_done   = (q.st == SQ_READ) && bus_ack;

        d     = q;
        d.vld = 1'b0;
        unique case (q.st)
            SQ_IDLE: begin
                if (launch) begin
                    d.st = SQ_WRITE;
                end else if (fetch) begin
                    d.st = SQ_READ;
                end else if (acc_rd_plain) begin
                    d.vld   = 1'b1;
                    d.rbyte = mux_byte;
                end
            end
            SQ_WRITE: begin
                if (bus_ack) d.st = SQ_IDLE;
            end
            SQ_READ: begin
                if (bus_ack) begin
                    d.st    = SQ_IDLE;
                    d.vld   = 1'b1;
                    d.rbyte = ack_byte;
                end
            end
            default: d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: SQ_IDLE, vld: 1'b0, rbyte: '0};
        else        q <= d;
    end

    assign busy      = (q.st != SQ_IDLE);
    assign bus_req   = (q.st != SQ_IDLE);
    assign bus_we    = (q.st == SQ_WRITE);
    assign bus_addr  = ((q.st == SQ_WRITE) ? waddr : raddr) & ALIGN_MASK;
    assign bus_wdata = wdata;
    assign rd_vld    = q.vld;
    assign rd_byte   = q.rbyte;

    AST_FETCH_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch |=> busy && !rd_vld); // R7
    AST_ACK_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> rd_vld && !busy); // R7
    AST_WR_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> bus_req && bus_we); // R6
    AST_BUSY_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bus_ack |=> busy); // R9
    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy && bus_ack |=> !busy); // R9
    AST_PLAIN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd_plain |=> rd_vld); // R10
    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_load, acc_wr, acc_rd})); // R11

endmodule

// File: rtl/ind_win_top.sv
module ind_win_top
    import ind_win_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ptr_load,
    input  logic [7:0]  ptr_val,
    input  logic        wr_stb,
    input  logic [7:0]  wr_byte,
    input  logic        rd_req,
    output logic        rd_vld,
    output logic [7:0]  rd_byte,
    output logic [7:0]  ptr_out,
    output logic        busy,
    output logic        bus_req,
    output logic        bus_we,
    output logic [31:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata
);

    logic [PTR_W-1:0]  ptr_q;
    logic [WORD_W-1:0] waddr, wdata, raddr;
    logic [BYTE_W-1:0] mux_byte;
    logic              acc_load, acc_wr, acc_rd_plain, fetch_done;

    ind_win_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .ptr_load     (ptr_load),
        .wr_stb       (wr_stb),
        .rd_req       (rd_req),
        .ptr          (ptr_q),
        .waddr        (waddr),
        .wdata        (wdata),
        .raddr        (raddr),
        .mux_byte     (mux_byte),
        .ack_byte     (bus_rdata[BYTE_W-1:0]),
        .bus_ack      (bus_ack),
        .acc_load     (acc_load),
        .acc_wr       (acc_wr),
        .acc_rd_plain (acc_rd_plain),
        .fetch_done   (fetch_done),
        .busy         (busy),
        .bus_req      (bus_req),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .rd_vld       (rd_vld),
        .rd_byte      (rd_byte)
    );

    ind_win_ptr u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (acc_load),
        .load_val   (ptr_val),
        .adv_wr     (acc_wr),
        .adv_rd     (acc_rd_plain),
        .fetch_done (fetch_done),
        .ptr_q      (ptr_q)
    );

    ind_win_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_wr),
        .wr_addr   (ptr_q),
        .wr_byte   (wr_byte),
        .ld_rdata  (fetch_done),
        .bus_rdata (bus_rdata),
        .rd_addr   (ptr_q),
        .rd_byte   (mux_byte),
        .waddr     (waddr),
        .wdata     (wdata),
        .raddr     (raddr)
    );

    assign ptr_out = ptr_q;

    AST_BUSY_FREEZES_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bus_ack |=> $stable(ptr_out)); // R9

endmodule

// File: tb/ind_win_top_test.sv
`timescale 1ns/1ps
module ind_win_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_load = 1'b0;
    logic [7:0]  ptr_val = '0;
    logic        wr_stb = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        rd_req = 1'b0;
    logic        rd_vld;
    logic [7:0]  rd_byte;
    logic [7:0]  ptr_out;
    logic        busy, bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack;
    logic [31:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    ind_win_top uut (
        .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_val(ptr_val),
        .wr_stb(wr_stb), .wr_byte(wr_byte), .rd_req(rd_req), .rd_vld(rd_vld),
        .rd_byte(rd_byte), .ptr_out(ptr_out), .busy(busy), .bus_req(bus_req),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    // bus model: acknowledges after a fixed latency, logs the access
    localparam int ACK_LAT = 3;
    int          lat_cnt;
    logic        ack_q;
    logic        log_we;
    logic [31:0] log_addr, log_wdata;
    int          n_bus;

    function automatic logic [31:0] model_data(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0] ^ 16'hC3E1};
    endfunction

    assign bus_ack   = ack_q;
    assign bus_rdata = ack_q ? model_data(bus_addr) : 32'hFFFF_FFFF;

    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0; lat_cnt <= 0; n_bus <= 0;
            log_we <= 1'b0; log_addr <= '0; log_wdata <= '0;
        end else begin
            ack_q <= 1'b0;
            if (bus_req && !ack_q) begin
                if (lat_cnt == ACK_LAT) begin
                    ack_q     <= 1'b1;
                    lat_cnt   <= 0;
                    n_bus     <= n_bus + 1;
                    log_we    <= bus_we;
                    log_addr  <= bus_addr;
                    log_wdata <= bus_wdata;
                end else begin
                    lat_cnt <= lat_cnt + 1;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_ptr(input logic [7:0] v);
        ptr_load = 1'b1; ptr_val = v;
        tick();
        ptr_load = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        wr_stb = 1'b1; wr_byte = b;
        tick();
        wr_stb = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int k = 0;
        while (busy && k < 50) begin
            tick();
            k++;
        end
        chk({tag, " busy clears"}, 32'(busy), 32'd0);
    endtask

    // returns the byte; handles bus fetch by polling rd_vld
    task automatic rd(input string tag, output logic [7:0] b);
        int k = 0;
        rd_req = 1'b1;
        tick();
        rd_req = 1'b0;
        if (busy) begin
            while (!rd_vld && k < 50) begin
                tick();
                k++;
            end
        end
        chk({tag, " rd_vld"}, 32'(rd_vld), 32'd1);
        b = rd_byte;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        chk("R1 ptr", 32'(ptr_out), 32'h00);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 bus_req", 32'(bus_req), 32'd0);
        chk("R1 rd_vld", 32'(rd_vld), 32'd0);
        rd("R1 waddr0", b);
        chk("R1 waddr byte0 zero", 32'(b), 32'h00);
        set_ptr(8'h13);
        rd("R1 raddr3", b);
        chk("R1 raddr byte3 zero", 32'(b), 32'h00);
    endtask

    task automatic t_load();
        set_ptr(8'hA7);
        chk("R2 load A7", 32'(ptr_out), 32'hA7);
        set_ptr(8'h00);
        chk("R2 load 00", 32'(ptr_out), 32'h00);
    endtask

    task automatic t_lanes();
        logic [7:0] b;
        set_ptr(8'h10);
        wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
        chk("R5 ptr after raddr", 32'(ptr_out), 32'h14);
        set_ptr(8'h10);
        for (int i = 0; i < 4; i++) begin
            rd("R3 raddr", b);
            chk($sformatf("R3 raddr lane %0d", i), 32'(b), 32'(8'h11 * (i + 1)));
        end
        // plain read: one-cycle pulse
        set_ptr(8'h11);
        rd("R10 plain", b);
        chk("R10 byte", 32'(b), 32'h22);
        tick();
        chk("R10 pulse ends", 32'(rd_vld), 32'd0);
    endtask

    task automatic t_unmapped();
        logic [7:0] b;
        set_ptr(8'h08);
        wr(8'hEE);
        chk("R4 ptr after unmapped write", 32'(ptr_out), 32'h09);
        set_ptr(8'h08);
        rd("R4 unmapped", b);
        chk("R4 unmapped 08 reads zero", 32'(b), 32'h00);
        set_ptr(8'h1C);
        rd("R4 unmapped", b);
        chk("R4 unmapped 1C reads zero", 32'(b), 32'h00);
        set_ptr(8'h15);
        wr(8'h77);
        set_ptr(8'h15);
        rd("R4 rdata", b);
        chk("R4 rdata write ignored", 32'(b), 32'h00);
    endtask

    task automatic t_top();
        logic [7:0] b;
        set_ptr(8'hFF);
        wr(8'h5A);
        chk("R5 write at FF holds", 32'(ptr_out), 32'hFF);
        rd("R5 FF", b);
        chk("R5 read at FF holds", 32'(ptr_out), 32'hFF);
        chk("R4 FF reads zero", 32'(b), 32'h00);
    endtask

    task automatic t_bus_write();
        logic [7:0] b;
        int nb;
        set_ptr(8'h00);
        wr(8'h7B); wr(8'h56); wr(8'h34); wr(8'h12);
        wr(8'hEF); wr(8'hBE); wr(8'hAD);
        nb = n_bus;
        wr(8'hDE);
        chk("R9 busy after launch", 32'(busy), 32'd1);
        chk("R6 bus_we", 32'(bus_we), 32'd1);
        chk("R6 aligned addr", bus_addr, 32'h1234_5678);
        chk("R6 wdata", bus_wdata, 32'hDEAD_BEEF);
        chk("R6 ptr rewinds", 32'(ptr_out), 32'h04);
        // strobes while busy are ignored
        wr(8'h99);
        ptr_load = 1'b1; ptr_val = 8'h30;
        tick();
        ptr_load = 1'b0;
        chk("R9 ptr frozen", 32'(ptr_out), 32'h04);
        wait_idle("R9");
        chk("R6 one bus write", 32'(n_bus - nb), 32'd1);
        chk("R6 logged we", 32'(log_we), 32'd1);
        rd("R9 wdata lsb", b);
        chk("R9 wdata kept", 32'(b), 32'hEF);
        // stream a second word through the same register
        set_ptr(8'h04);
        wr(8'h04); wr(8'h03); wr(8'h02); wr(8'h01);
        wait_idle("R6 second");
        chk("R6 second wdata", log_wdata, 32'h0102_0304);
        chk("R6 second addr", log_addr, 32'h1234_5678);
        set_ptr(8'h07);
        rd("R6 read 07", b);
        chk("R6 read 07 byte", 32'(b), 32'h01);
        chk("R6 read 07 ptr", 32'(ptr_out), 32'h08);
    endtask

    task automatic t_bus_read();
        logic [7:0] b;
        logic [31:0] exp;
        set_ptr(8'h10);
        wr(8'h03); wr(8'h10); wr(8'h00); wr(8'h00);
        exp = model_data(32'h0000_1000);
        rd_req = 1'b1;
        tick();
        rd_req = 1'b0;
        chk("R7 busy on fetch", 32'(busy), 32'd1);
        chk("R7 no early rd_vld", 32'(rd_vld), 32'd0);
        chk("R7 bus_we low", 32'(bus_we), 32'd0);
        chk("R7 aligned addr", bus_addr, 32'h0000_1000);
        for (int k = 0; k < 50 && !rd_vld; k++) tick();
        chk("R7 rd_vld after ack", 32'(rd_vld), 32'd1);
        chk("R7 byte0", 32'(rd_byte), 32'(exp[7:0]));
        chk("R7 ptr 15", 32'(ptr_out), 32'h15);
        chk("R9 idle after ack", 32'(busy), 32'd0);
        for (int i = 1; i < 4; i++) begin
            rd("R7 upper", b);
            chk($sformatf("R7 byte%0d", i), 32'(b), 32'(exp[i*8 +: 8]));
        end
        chk("R8 read 17 rewinds", 32'(ptr_out), 32'h14);
        raddr_bump();
        exp = model_data(32'h0000_2000);
        rd("R8 streamed fetch", b);
        chk("R8 second word byte0", 32'(b), 32'(exp[7:0]));
        set_ptr(8'h17);
        wr(8'h66);
        chk("R8 write 17 ptr", 32'(ptr_out), 32'h18);
        set_ptr(8'h17);
        rd("R8 after write", b);
        chk("R8 write 17 ignored", 32'(b), 32'(exp[31:24]));
    endtask

    task automatic raddr_bump();
        set_ptr(8'h11);
        wr(8'h20);
        set_ptr(8'h14);
    endtask

    task automatic t_priority();
        logic [7:0] b;
        set_ptr(8'h10);
        ptr_load = 1'b1; ptr_val = 8'h40; wr_stb = 1'b1; wr_byte = 8'h99; rd_req = 1'b1;
        tick();
        ptr_load = 1'b0; wr_stb = 1'b0; rd_req = 1'b0;
        chk("R11 load wins", 32'(ptr_out), 32'h40);
        chk("R11 read dropped", 32'(rd_vld), 32'd0);
        set_ptr(8'h10);
        rd("R11 raddr", b);
        chk("R11 write dropped", 32'(b), 32'h03);
        set_ptr(8'h12);
        wr_stb = 1'b1; wr_byte = 8'h5C; rd_req = 1'b1;
        tick();
        wr_stb = 1'b0; rd_req = 1'b0;
        chk("R11 write beats read", 32'(rd_vld), 32'd0);
        chk("R11 ptr advanced once", 32'(ptr_out), 32'h13);
        set_ptr(8'h12);
        rd("R11 written", b);
        chk("R11 byte stored", 32'(b), 32'h5C);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_load();
        t_lanes();
        t_unmapped();
        t_top();
        t_bus_write();
        t_bus_read();
        t_priority();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule